// File: doc/BRIEF.md
# Parallel Union-Find Syndrome Decoder Grid

This block clusters surface-code defects on a two-dimensional decoding graph. Every graph vertex has its own small processing element, and every edge has its own growth counter. An element exchanges cluster identifiers only with the four elements next to it in the grid. A single stage controller moves the whole array through the same phases in lock step: grow the odd clusters, spread the smallest identifier across fully grown edges until nothing changes, fold the syndrome parity of each cluster to its root, then decide whether to stop.

The left and right columns each have an extra edge to a virtual boundary. That boundary has permanently even parity, so any cluster that reaches it counts as neutral. The host places a syndrome vector on the input and pulses `start`. It waits for `done`, then reads the per-vertex cluster identifiers and the mask of fully grown edges. A correction stage would consume these.

Top module: `uf_decoder_array`

## Requirements
- R1: While reset is held and in the cycle after it, every cluster identifier equals its own vertex index, the edge mask is all zero and `done` is low.
- R2: A `start` pulse clears every edge counter, reloads each identifier to its own vertex index and seeds each vertex's odd flag from its syndrome bit. `done` is low in the cycle after the pulse.
- R3: In each grow phase, an edge gains one half-step from each endpoint that lies in an odd cluster, and the counter saturates at two. An edge is fully grown at two, so a single grow phase completes an edge whose two endpoints are both odd. A fully grown edge stays grown until the next `start`.
- R4: When decoding ends, every vertex's identifier equals the smallest vertex index among all vertices joined to it through fully grown edges. Identifiers never increase during a run.
- R5: A cluster is odd when the XOR of its members' syndrome bits is one and none of its members has a fully grown boundary edge. Only odd clusters grow.
- R6: `done` rises once a parity fold finds no odd cluster. It then stays high, with identifiers and edge mask unchanged, until the next `start`.
- R7: Edge mask bit positions are fixed, with H = ROWS*(COLS-1) and V = (ROWS-1)*COLS. Bit r*(COLS-1)+c is the edge between vertices (r,c) and (r,c+1). Bit H+r*COLS+c is the edge between (r,c) and (r+1,c). Bit H+V+r is the left boundary edge of (r,0). Bit H+V+ROWS+r is the right boundary edge of (r,COLS-1).
- R8: Vertex (r,c) has index r*COLS+c. Its identifier occupies `cluster_ids[i*IDW +: IDW]`, with IDW = clog2(ROWS*COLS), and it never exceeds the vertex's own index.
- R9: An all-zero syndrome finishes with an empty edge mask and every identifier equal to its own index.
- R10: A `start` pulse during a run abandons that run. The result is the same as a run started from idle with the new syndrome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decoding the current syndrome |
| syndrome | input | ROWS*COLS | One defect bit per vertex, index r*COLS+c |
| cluster_ids | output | ROWS*COLS*IDW | Per-vertex cluster identifier |
| edge_full | output | H+V+2*ROWS | Fully grown edge mask |
| done | output | 1 | Decoding finished |

## Verification
The collision that matters is two growth contributions reaching the same edge counter in one grow phase. This happens when both endpoints belong to odd clusters. The counter must then reach "fully grown" in that single step without wrapping, and the merge that follows must make the combined cluster even, so it stops growing. The bench provokes this with two adjacent defects, checks that exactly that one edge bit is set, and checks that none of the neighbouring edges grew a second time. Random syndromes create the same overlap between larger clusters. Those results are judged on cluster minimality and even-or-boundary parity, both computed from the reported edge mask.

// File: rtl/uf_pkg.sv
package uf_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GROW,
        PH_MERGE,
        PH_PARITY,
        PH_CHECK,
        PH_DONE
    } phase_t;

    typedef logic [1:0] grow_cnt_t;

    localparam grow_cnt_t CNT_FULL = 2'd2;

    // one half-step per odd endpoint, saturating at fully grown
    function automatic grow_cnt_t grow_step(grow_cnt_t cur, logic odd_a, logic odd_b);
        logic [2:0] sum;
        sum = {1'b0, cur} + {2'b00, odd_a} + {2'b00, odd_b};
        return (sum >= 3'd2) ? CNT_FULL : sum[1:0];
    endfunction

endpackage

// File: rtl/uf_edge_ctr.sv
module uf_edge_ctr
    import uf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic grow_en,
    input  logic odd_a,
    input  logic odd_b,
    output logic full
);

    grow_cnt_t cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (grow_en) begin
            cnt <= grow_step(cnt, odd_a, odd_b);
        end
    end

    assign full = (cnt == CNT_FULL);

endmodule

// File: rtl/uf_vertex_pe.sv
module uf_vertex_pe #(
    parameter int IDW  = 4,
    parameter int SELF = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic                     syn_in,
    input  logic                     merge_en,
    input  logic                     par_en,
    input  logic [3:0][IDW-1:0]      nb_id,
    input  logic [3:0]               nb_link,
    input  logic                     clu_odd,
    output logic [IDW-1:0]           id,
    output logic                     syn,
    output logic                     odd,
    output logic                     changed
);

    localparam logic [IDW-1:0] SELF_ID = IDW'(SELF);

    logic [IDW-1:0] best;

    // minimum over own id and ids across fully grown edges
    always_comb begin
        best = id;
        for (int k = 0; k < 4; k++) begin
            if (nb_link[k] && (nb_id[k] < best)) begin
                best = nb_id[k];
            end
        end
        changed = merge_en && (best != id);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            id  <= SELF_ID;
            syn <= 1'b0;
            odd <= 1'b0;
        end else if (load) begin
            id  <= SELF_ID;
            syn <= syn_in;
            odd <= syn_in;
        end else begin
            if (merge_en) id  <= best;
            if (par_en)   odd <= clu_odd;
        end
    end

endmodule

// File: rtl/uf_parity_tree.sv
module uf_parity_tree #(
    parameter int NV  = 9,
    parameter int IDW = 4
) (
    input  logic [NV-1:0][IDW-1:0] ids,
    input  logic [NV-1:0]          syn,
    input  logic [NV-1:0]          touch,
    output logic [NV-1:0]          vodd
);

    logic [NV-1:0] root_par;
    logic [NV-1:0] root_tch;
    logic [NV-1:0] root_odd;

    // fold parity and boundary contact per root
    always_comb begin
        for (int k = 0; k < NV; k++) begin
            root_par[k] = 1'b0;
            root_tch[k] = 1'b0;
            for (int i = 0; i < NV; i++) begin
                if (ids[i] == IDW'(k)) begin
                    root_par[k] = root_par[k] ^ syn[i];
                    root_tch[k] = root_tch[k] | touch[i];
                end
            end
            root_odd[k] = root_par[k] & ~root_tch[k];
        end
    end

    // broadcast the root verdict back to members
    always_comb begin
        for (int i = 0; i < NV; i++) begin
            vodd[i] = 1'b0;
            for (int k = 0; k < NV; k++) begin
                if (ids[i] == IDW'(k)) vodd[i] = root_odd[k];
            end
        end
    end

endmodule

// File: rtl/uf_stage_ctrl.sv
module uf_stage_ctrl
    import uf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   chg_any,
    input  logic   odd_any,
    output phase_t ph
);

    logic chg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            chg_q <= 1'b0;
        end else begin
            // forced high on merge entry so at least two merge cycles run
            chg_q <= (ph == PH_GROW) ? 1'b1 : chg_any;
            if (start) begin
                ph <= PH_GROW;
            end else begin
                case (ph)
                    PH_GROW:   ph <= PH_MERGE;
                    PH_MERGE:  if (!chg_q) ph <= PH_PARITY;
                    PH_PARITY: ph <= PH_CHECK;
                    PH_CHECK:  ph <= odd_any ? PH_GROW : PH_DONE;
                    default:   ph <= ph;
                endcase
            end
        end
    end

endmodule

// File: rtl/uf_decoder_array.sv
module uf_decoder_array
    import uf_pkg::*;
#(
    parameter int ROWS = 3,
    parameter int COLS = 3,
    localparam int NV  = ROWS * COLS,
    localparam int IDW = (NV > 1) ? $clog2(NV) : 1,
    localparam int NH  = ROWS * (COLS - 1),
    localparam int NVE = (ROWS - 1) * COLS,
    localparam int NE  = NH + NVE + 2 * ROWS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [NV-1:0]       syndrome,
    output logic [NV*IDW-1:0]   cluster_ids,
    output logic [NE-1:0]       edge_full,
    output logic                done
);

    localparam int BW = NH + NVE;
    localparam int BE = NH + NVE + ROWS;

    phase_t                 ph;
    logic [NV-1:0][IDW-1:0] ids;
    logic [NV-1:0]          vsyn, vodd, vchg, touch, clu_odd;
    logic [NE-1:0]          efull;
    logic                   grow_en, merge_en, par_en;

    assign grow_en  = (ph == PH_GROW)   && !start;
    assign merge_en = (ph == PH_MERGE)  && !start;
    assign par_en   = (ph == PH_PARITY) && !start;

    uf_stage_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .chg_any (|vchg),
        .odd_any (|vodd),
        .ph      (ph)
    );

    // horizontal edges
    for (genvar r = 0; r < ROWS; r++) begin : g_hr
        for (genvar c = 0; c < COLS - 1; c++) begin : g_hc
            uf_edge_ctr u_e (
                .clk(clk), .rst(rst), .clr(start), .grow_en(grow_en),
                .odd_a(vodd[r*COLS+c]), .odd_b(vodd[r*COLS+c+1]),
                .full(efull[r*(COLS-1)+c])
            );
        end
    end

    // vertical edges
    for (genvar r = 0; r < ROWS - 1; r++) begin : g_vr
        for (genvar c = 0; c < COLS; c++) begin : g_vc
            uf_edge_ctr u_e (
                .clk(clk), .rst(rst), .clr(start), .grow_en(grow_en),
                .odd_a(vodd[r*COLS+c]), .odd_b(vodd[(r+1)*COLS+c]),
                .full(efull[NH+r*COLS+c])
            );
        end
    end

    // boundary edges, one live endpoint each
    for (genvar r = 0; r < ROWS; r++) begin : g_bnd
        uf_edge_ctr u_w (
            .clk(clk), .rst(rst), .clr(start), .grow_en(grow_en),
            .odd_a(vodd[r*COLS]), .odd_b(1'b0),
            .full(efull[BW+r])
        );
        uf_edge_ctr u_e (
            .clk(clk), .rst(rst), .clr(start), .grow_en(grow_en),
            .odd_a(vodd[r*COLS+COLS-1]), .odd_b(1'b0),
            .full(efull[BE+r])
        );
    end

    // processing elements with nearest-neighbour links (0=N,1=S,2=W,3=E)
    for (genvar r = 0; r < ROWS; r++) begin : g_pr
        for (genvar c = 0; c < COLS; c++) begin : g_pc
            localparam int V = r * COLS + c;
            logic [3:0][IDW-1:0] nid;
            logic [3:0]          nl;
            logic                tw, te;

            if (r > 0) begin : g_n
                assign nid[0] = ids[V-COLS];
                assign nl[0]  = efull[NH+(r-1)*COLS+c];
            end else begin : g_nn
                assign nid[0] = '0;
                assign nl[0]  = 1'b0;
            end
            if (r < ROWS - 1) begin : g_s
                assign nid[1] = ids[V+COLS];
                assign nl[1]  = efull[NH+r*COLS+c];
            end else begin : g_ns
                assign nid[1] = '0;
                assign nl[1]  = 1'b0;
            end
            if (c > 0) begin : g_w
                assign nid[2] = ids[V-1];
                assign nl[2]  = efull[r*(COLS-1)+c-1];
                assign tw     = 1'b0;
            end else begin : g_nw
                assign nid[2] = '0;
                assign nl[2]  = 1'b0;
                assign tw     = efull[BW+r];
            end
            if (c < COLS - 1) begin : g_e
                assign nid[3] = ids[V+1];
                assign nl[3]  = efull[r*(COLS-1)+c];
                assign te     = 1'b0;
            end else begin : g_ne
                assign nid[3] = '0;
                assign nl[3]  = 1'b0;
                assign te     = efull[BE+r];
            end
            assign touch[V] = tw | te;

            uf_vertex_pe #(.IDW(IDW), .SELF(V)) u_pe (
                .clk      (clk),
                .rst      (rst),
                .load     (start),
                .syn_in   (syndrome[V]),
                .merge_en (merge_en),
                .par_en   (par_en),
                .nb_id    (nid),
                .nb_link  (nl),
                .clu_odd  (clu_odd[V]),
                .id       (ids[V]),
                .syn      (vsyn[V]),
                .odd      (vodd[V]),
                .changed  (vchg[V])
            );
        end
    end

    uf_parity_tree #(.NV(NV), .IDW(IDW)) u_par (
        .ids   (ids),
        .syn   (vsyn),
        .touch (touch),
        .vodd  (clu_odd)
    );

    assign cluster_ids = ids;
    assign edge_full   = efull;
    assign done        = (ph == PH_DONE);

endmodule

// File: rtl/uf_decoder_checker.sv
module uf_decoder_checker #(
    parameter int ROWS = 3,
    parameter int COLS = 3,
    localparam int NV  = ROWS * COLS,
    localparam int IDW = (NV > 1) ? $clog2(NV) : 1,
    localparam int NE  = ROWS * (COLS - 1) + (ROWS - 1) * COLS + 2 * ROWS
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [NV*IDW-1:0] cluster_ids,
    input logic [NE-1:0]     edge_full,
    input logic              done
);

    assert_start_clears_done_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);

    assert_start_clears_edges_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (edge_full == '0));

    assert_done_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    assert_result_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> ($stable(cluster_ids) && $stable(edge_full)));

    for (genvar e = 0; e < NE; e++) begin : g_edge
        assert_edge_stays_full_R3: assert property (@(posedge clk) disable iff (rst)
            (edge_full[e] && !start) |=> edge_full[e]);
    end

    for (genvar i = 0; i < NV; i++) begin : g_vert
        assert_id_reload_R2: assert property (@(posedge clk) disable iff (rst)
            start |=> (cluster_ids[i*IDW +: IDW] == IDW'(i)));

        assert_id_nonincreasing_R4: assert property (@(posedge clk) disable iff (rst)
            !start |=> (cluster_ids[i*IDW +: IDW] <= $past(cluster_ids[i*IDW +: IDW])));

        assert_id_bound_R8: assert property (@(posedge clk) disable iff (rst)
            cluster_ids[i*IDW +: IDW] <= IDW'(i));
    end

endmodule

bind uf_decoder_array uf_decoder_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .cluster_ids (cluster_ids),
    .edge_full   (edge_full),
    .done        (done)
);

// File: tb/uf_decoder_array_tb.sv
module uf_decoder_array_tb;

    localparam int ROWS = 5;
    localparam int COLS = 5;
    localparam int NV   = ROWS * COLS;
    localparam int IDW  = $clog2(NV);
    localparam int NH   = ROWS * (COLS - 1);
    localparam int NVE  = (ROWS - 1) * COLS;
    localparam int NE   = NH + NVE + 2 * ROWS;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic [NV-1:0]       syndrome = '0;
    logic [NV*IDW-1:0]   cluster_ids;
    logic [NE-1:0]       edge_full;
    logic                done;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;

    always #4 clk = ~clk;   // 125 MHz

    uf_decoder_array #(.ROWS(ROWS), .COLS(COLS)) u_dut (
        .clk(clk), .rst(rst), .start(start), .syndrome(syndrome),
        .cluster_ids(cluster_ids), .edge_full(edge_full), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int id_of(int i);
        return int'(cluster_ids[i*IDW +: IDW]);
    endfunction

    // endpoints per edge encoding of R7; b = -1 marks the boundary
    function automatic void ends(input int e, output int a, output int b);
        if (e < NH) begin
            a = (e / (COLS-1)) * COLS + e % (COLS-1); b = a + 1;
        end else if (e < NH + NVE) begin
            a = e - NH; b = a + COLS;
        end else if (e < NH + NVE + ROWS) begin
            a = (e - NH - NVE) * COLS; b = -1;
        end else begin
            a = (e - NH - NVE - ROWS) * COLS + COLS - 1; b = -1;
        end
    endfunction

    // judge a finished run from the reported edges (R4, R5, R8)
    task automatic judge(input logic [NV-1:0] s);
        int lbl [NV];
        int a, b;
        bit par [NV];
        bit tch [NV];
        for (int i = 0; i < NV; i++) begin lbl[i] = i; par[i] = 0; tch[i] = 0; end
        for (int it = 0; it < NV; it++) begin
            for (int e = 0; e < NH + NVE; e++) begin
                if (edge_full[e]) begin
                    ends(e, a, b);
                    if (lbl[a] < lbl[b]) lbl[b] = lbl[a]; else lbl[a] = lbl[b];
                end
            end
        end
        for (int i = 0; i < NV; i++) begin
            chk(id_of(i) == lbl[i], "R4 min id", id_of(i), lbl[i]);
            par[lbl[i]] ^= s[i];
        end
        for (int e = NH + NVE; e < NE; e++) begin
            if (edge_full[e]) begin ends(e, a, b); tch[lbl[a]] = 1; end
        end
        for (int k = 0; k < NV; k++) begin
            chk(!(par[k] && !tch[k]), "R5 odd cluster left", par[k], 0);
        end
    endtask

    task automatic wait_done();
        int w = 0;
        while (!done && w < 4000) begin @(negedge clk); w++; end
        chk(done, "R6 done", done, 1);
    endtask

    task automatic pulse(input logic [NV-1:0] s);
        @(negedge clk);
        start = 1'b1; syndrome = s;
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R2 done low after start", done, 0);
    endtask

    task automatic run(input logic [NV-1:0] s);
        pulse(s);
        wait_done();
    endtask

    function automatic logic [NV-1:0] rnd_syn();
        logic [NV-1:0] s;
        for (int i = 0; i < NV; i++) s[i] = (($urandom % 5) == 0);
        return s;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [NV-1:0]       sa, sb;
        logic [NV*IDW-1:0]   ref_ids;
        logic [NE-1:0]       ref_edges;
        logic [NE-1:0]       exp_e;
        void'($urandom(32'h1d5e));

        repeat (4) @(negedge clk);
        for (int i = 0; i < NV; i++) chk(id_of(i) == i, "R1 id in reset", id_of(i), i);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NV; i++) chk(id_of(i) == i, "R1 id after reset", id_of(i), i);
        chk(edge_full == '0, "R1 edges", edge_full, 0);
        chk(!done, "R1 done", done, 0);

        // R9 empty syndrome
        run('0);
        chk(edge_full == '0, "R9 edges", edge_full, 0);
        for (int i = 0; i < NV; i++) chk(id_of(i) == i, "R9 id", id_of(i), i);

        // R3 both endpoints odd in one step: only edge 0 grows fully
        sa = '0; sa[0] = 1'b1; sa[1] = 1'b1;
        run(sa);
        exp_e = '0; exp_e[0] = 1'b1;
        chk(edge_full == exp_e, "R3 twin defects", edge_full, exp_e);
        chk(id_of(1) == 0, "R4 twin id", id_of(1), 0);
        chk(id_of(2) == 2, "R4 untouched id", id_of(2), 2);

        // R5/R7 corner defect reaches left boundary after two grows
        sa = '0; sa[0] = 1'b1;
        run(sa);
        exp_e = '0; exp_e[0] = 1'b1; exp_e[NH] = 1'b1; exp_e[NH+NVE] = 1'b1;
        chk(edge_full == exp_e, "R7 corner edges", edge_full, exp_e);
        chk(id_of(5) == 0, "R4 corner south id", id_of(5), 0);
        chk(id_of(6) == 6, "R5 neutral stops growth", id_of(6), 6);
        judge(sa);

        // R6 result holds while idle
        ref_ids = cluster_ids; ref_edges = edge_full;
        repeat (20) @(negedge clk);
        chk(done && cluster_ids == ref_ids, "R6 ids hold", cluster_ids, ref_ids);
        chk(edge_full == ref_edges, "R6 edges hold", edge_full, ref_edges);

        // R10 restart mid-run equals a fresh run
        sa = rnd_syn(); sa[12] = 1'b1;
        sb = rnd_syn(); sb[3] = 1'b1;
        run(sb);
        ref_ids = cluster_ids; ref_edges = edge_full;
        pulse(sa);
        repeat (2) @(negedge clk);
        run(sb);
        chk(cluster_ids == ref_ids, "R10 restart ids", cluster_ids, ref_ids);
        chk(edge_full == ref_edges, "R10 restart edges", edge_full, ref_edges);

        // random syndromes
        for (int t = 0; t < 40; t++) begin
            sa = rnd_syn();
            run(sa);
            judge(sa);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule